// File: doc/BRIEF.md
# Slot Hotplug Event and Eject Controller

This block keeps the hotplug view of one bus with up to 32 device slots. For each slot it holds whether a device is present, whether the slot may be hot-removed, and whether a removal request is waiting for software. Per-slot event inputs report hot insertions, removal requests and devices found at boot. A hot event sets a bit in a small general-purpose event status byte, and a level interrupt output is high while any set status bit is also enabled.

Software sees the slot state through a 16-byte window of 32-bit registers. It learns which slots need a device check, which removals are pending, and which slots are removable. It completes a removal by writing an eject mask. Each eject write handles only the lowest slot named in the mask.

A reset request first drains every pending removal, one slot per cycle, while a busy output is high. It then rebuilds the present and removable masks from the slot occupancy inputs. A hardware reset takes the same path with nothing pending.

Top module: `slot_hp_ctrl`

## Requirements
- R1: The window decodes `req_addr[3:2]`. 0 is the device-check mask, 1 is the pending-removal mask, 2 is the eject register and 3 is the removable mask. An access is accepted only when `req_be` is 4'hF and `req_addr[1:0]` is 0. Any other access changes no state and reads as zero. Every read request produces `rd_valid` one cycle later, with `rd_data` in the same cycle.
- R2: A read of index 0 returns present AND removable, taken from the state at the cycle of the request. Nothing is latched.
- R3: A read of index 2 returns zero. A read of index 3 returns the removable mask.
- R4: An accepted write to index 2 selects the lowest set bit of the written data. It clears that slot's pending-removal bit. It also clears the slot's present bit unless `fixed_fn` is set for that slot. A write of zero, or a write to any other index, has no effect.
- R5: A hot insert sets the slot's present bit. A hot remove sets the slot's pending-removal bit. Either one sets bit 1 of `gpe_sts` on the next edge.
- R6: A coldplug insert sets the present bit only. It does not set `gpe_sts` and does not raise `sci`.
- R7: `sci` is high while `gpe_sts & gpe_en` is nonzero. A 1 on a `gpe_clr` bit clears that status bit, but a hot event in the same cycle wins.
- R8: If an eject and a hot insert hit the same slot in one cycle, the eject is applied first, so the slot ends present. If an eject and a hot remove hit the same slot in one cycle, the removal stays pending.
- R9: While idle, a `reset_req` pulse raises `busy` on the next edge. While busy, one pending removal per cycle, lowest slot first, is processed as an eject. While busy, events, eject writes and further reset requests are ignored.
- R10: In the cycle after the pending-removal mask is empty, present becomes `occupied`, removable becomes NOT (`occupied` AND `fixed_fn`), and `busy` drops. `busy` is high during hardware reset and for one cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_req | input | 1 | Request to drain pending removals and rebuild the masks |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte offset in the window |
| req_be | input | 4 | Byte enables; must be 4'hF |
| req_wdata | input | 32 | Write data, little-endian |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| ins_evt | input | NUM_SLOTS | Per-slot hot insert pulse |
| rem_evt | input | NUM_SLOTS | Per-slot hot removal request pulse |
| cold_ins | input | NUM_SLOTS | Per-slot boot-time presence pulse |
| occupied | input | NUM_SLOTS | Current slot occupancy, used by the rebuild |
| fixed_fn | input | NUM_SLOTS | Slot holds a function that cannot be hot-removed |
| gpe_en | input | 8 | Event enable byte |
| gpe_clr | input | 8 | Write-one-to-clear strobe for the event status byte |
| gpe_sts | output | 8 | Event status byte |
| sci | output | 1 | Level interrupt |
| busy | output | 1 | Drain or rebuild in progress |

## Verification
The assertions assume that event inputs are one-cycle pulses driven between clock edges. They also assume that the inputs seen during reset are quiet, because some properties look one cycle back across the release of reset. The bench drives every input half a cycle after the rising edge and keeps all request and event inputs at zero during hardware reset. It raises events only sparsely, so the status byte is cleared often enough to show a set and a clear in separate cycles. The random phase still includes same-cycle eject, insert and removal collisions, and reset requests that arrive while removals are pending.

// File: rtl/slot_hp_pkg.sv
package slot_hp_pkg;

   localparam int unsigned REG_W = 32;
   localparam int unsigned GPE_W = 8;

   // register index taken from address bits [3:2]
   typedef enum logic [1:0] {
      IDX_CHECK  = 2'd0,
      IDX_PEND   = 2'd1,
      IDX_EJECT  = 2'd2,
      IDX_REMOV  = 2'd3
   } reg_idx_e;

   typedef enum logic {
      ST_RUN   = 1'b0,
      ST_DRAIN = 1'b1
   } slot_st_e;

   function automatic logic [REG_W-1:0] lowest_one(input logic [REG_W-1:0] v);
      return v & (~v + {{(REG_W-1){1'b0}}, 1'b1});
   endfunction

endpackage

// File: rtl/slot_hp_regs.sv
module slot_hp_regs
   import slot_hp_pkg::*;
#(
   parameter int unsigned NUM_SLOTS = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic                  req_write,
   input  logic [3:0]            req_addr,
   input  logic [3:0]            req_be,
   input  logic [REG_W-1:0]      req_wdata,
   input  logic [NUM_SLOTS-1:0]  present,
   input  logic [NUM_SLOTS-1:0]  removable,
   input  logic [NUM_SLOTS-1:0]  pending,
   output logic [NUM_SLOTS-1:0]  ej_mask,
   output logic                  rd_valid,
   output logic [REG_W-1:0]      rd_data
);

   localparam int unsigned PAD = REG_W - NUM_SLOTS;

   logic             acc_ok;
   reg_idx_e         idx;
   logic [REG_W-1:0] check_w, pend_w, remov_w, low_w, mux_w;

   assign acc_ok = req_valid && (req_be == 4'hF) && (req_addr[1:0] == 2'b00);
   assign idx    = reg_idx_e'(req_addr[3:2]);

   generate
      if (PAD == 0) begin : g_nopad
         assign check_w = present & removable;
         assign pend_w  = pending;
         assign remov_w = removable;
      end else begin : g_pad
         assign check_w = {{PAD{1'b0}}, present & removable};
         assign pend_w  = {{PAD{1'b0}}, pending};
         assign remov_w = {{PAD{1'b0}}, removable};
      end
   endgenerate

   always_comb begin
      unique case (idx)
         IDX_CHECK: mux_w = check_w;
         IDX_PEND:  mux_w = pend_w;
         IDX_REMOV: mux_w = remov_w;
         default:   mux_w = '0;
      endcase
   end

   assign low_w   = lowest_one(req_wdata);
   assign ej_mask = (acc_ok && req_write && idx == IDX_EJECT) ? low_w[NUM_SLOTS-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= req_valid && !req_write;
         rd_data  <= (acc_ok && !req_write) ? mux_w : '0;
      end
   end

   // R1
   rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(req_valid && !req_write));

   // R3
   eject_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_addr[3:2] == 2'd2) |=> (rd_data == '0));

endmodule

// File: rtl/slot_hp_slots.sv
module slot_hp_slots
   import slot_hp_pkg::*;
#(
   parameter int unsigned NUM_SLOTS = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reset_req,
   input  logic [NUM_SLOTS-1:0]  ej_mask,
   input  logic [NUM_SLOTS-1:0]  ins_evt,
   input  logic [NUM_SLOTS-1:0]  rem_evt,
   input  logic [NUM_SLOTS-1:0]  cold_ins,
   input  logic [NUM_SLOTS-1:0]  occupied,
   input  logic [NUM_SLOTS-1:0]  fixed_fn,
   output logic [NUM_SLOTS-1:0]  present,
   output logic [NUM_SLOTS-1:0]  removable,
   output logic [NUM_SLOTS-1:0]  pending,
   output logic                  busy,
   output logic                  hp_event
);

   slot_st_e              st_q, st_nx;
   logic [NUM_SLOTS-1:0]  pres_q, rmv_q, pend_q;
   logic [NUM_SLOTS-1:0]  pres_nx, rmv_nx, pend_nx;
   logic [NUM_SLOTS-1:0]  drain_sel;
   logic                  pend_any, run;

   assign pend_any = |pend_q;
   assign run      = (st_q == ST_RUN) && !reset_req;
   assign hp_event = run && ((|ins_evt) || (|rem_evt));

   // pick the lowest pending slot for the drain walk
   always_comb begin
      logic seen;
      seen      = 1'b0;
      drain_sel = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (pend_q[i] && !seen) begin
            drain_sel[i] = 1'b1;
            seen         = 1'b1;
         end
      end
   end

   generate
      for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
         logic p_n, r_n, d_n;
         always_comb begin
            p_n = pres_q[g];
            r_n = rmv_q[g];
            d_n = pend_q[g];
            if (st_q == ST_DRAIN) begin
               if (pend_any) begin
                  if (drain_sel[g]) begin
                     d_n = 1'b0;
                     if (!fixed_fn[g]) p_n = 1'b0;
                  end
               end else begin
                  p_n = occupied[g];
                  r_n = !(occupied[g] && fixed_fn[g]);
               end
            end else if (run) begin
               // eject first, then new events
               if (ej_mask[g]) begin
                  d_n = 1'b0;
                  if (!fixed_fn[g]) p_n = 1'b0;
               end
               if (rem_evt[g]) d_n = 1'b1;
               if (ins_evt[g] || cold_ins[g]) p_n = 1'b1;
            end
         end
         assign pres_nx[g] = p_n;
         assign rmv_nx[g]  = r_n;
         assign pend_nx[g] = d_n;
      end
   endgenerate

   always_comb begin
      st_nx = st_q;
      if (st_q == ST_DRAIN && !pend_any) st_nx = ST_RUN;
      else if (st_q == ST_RUN && reset_req) st_nx = ST_DRAIN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_DRAIN;
         pres_q <= '0;
         rmv_q  <= '1;
         pend_q <= '0;
      end else begin
         st_q   <= st_nx;
         pres_q <= pres_nx;
         rmv_q  <= rmv_nx;
         pend_q <= pend_nx;
      end
   end

   assign present   = pres_q;
   assign removable = rmv_q;
   assign pending   = pend_q;
   assign busy      = (st_q == ST_DRAIN);

   // R4
   ej_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ej_mask));

   // R9
   drain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && pend_any) |=> ($countones(pending) + 1 == $countones($past(pending))));

   // R10
   rebuild_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !pend_any) |=> (!busy && present == $past(occupied)
                               && removable == ~($past(occupied) & $past(fixed_fn))));

endmodule

// File: rtl/slot_hp_gpe.sv
module slot_hp_gpe
   import slot_hp_pkg::*;
#(
   parameter int unsigned HP_BIT  = 1,
   parameter bit          SCI_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_evt,
   input  logic [GPE_W-1:0]  clr,
   input  logic [GPE_W-1:0]  en,
   output logic [GPE_W-1:0]  sts,
   output logic              sci
);

   logic [GPE_W-1:0] sts_q, set_vec;

   assign set_vec = set_evt ? (GPE_W'(1) << HP_BIT) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_q <= '0;
      else        sts_q <= (sts_q & ~clr) | set_vec;
   end

   assign sts = sts_q;

   generate
      if (SCI_REG) begin : g_sci_ff
         logic sci_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sci_q <= 1'b0;
            else        sci_q <= |(((sts_q & ~clr) | set_vec) & en);
         end
         assign sci = sci_q;
      end else begin : g_sci_comb
         assign sci = |(sts_q & en);
      end
   endgenerate

   // R5
   hp_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> sts[HP_BIT]);

   // R7
   sts_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts[HP_BIT] && clr[HP_BIT] && !set_evt) |=> !sts[HP_BIT]);

endmodule

// File: rtl/slot_hp_ctrl.sv
module slot_hp_ctrl
   import slot_hp_pkg::*;
#(
   parameter int unsigned NUM_SLOTS = 32,
   parameter int unsigned HP_BIT    = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reset_req,
   input  logic                  req_valid,
   input  logic                  req_write,
   input  logic [3:0]            req_addr,
   input  logic [3:0]            req_be,
   input  logic [31:0]           req_wdata,
   output logic                  rd_valid,
   output logic [31:0]           rd_data,
   input  logic [NUM_SLOTS-1:0]  ins_evt,
   input  logic [NUM_SLOTS-1:0]  rem_evt,
   input  logic [NUM_SLOTS-1:0]  cold_ins,
   input  logic [NUM_SLOTS-1:0]  occupied,
   input  logic [NUM_SLOTS-1:0]  fixed_fn,
   input  logic [7:0]            gpe_en,
   input  logic [7:0]            gpe_clr,
   output logic [7:0]            gpe_sts,
   output logic                  sci,
   output logic                  busy
);

   generate
      if (NUM_SLOTS < 1 || NUM_SLOTS > REG_W) begin : g_bad_slots
         $error("NUM_SLOTS must lie in 1..32");
      end
      if (HP_BIT >= GPE_W) begin : g_bad_bit
         $error("HP_BIT must index the event status byte");
      end
   endgenerate

   logic [NUM_SLOTS-1:0] ej_mask, present, removable, pending;
   logic                 hp_event;

   slot_hp_regs #(.NUM_SLOTS(NUM_SLOTS)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_be    (req_be),
      .req_wdata (req_wdata),
      .present   (present),
      .removable (removable),
      .pending   (pending),
      .ej_mask   (ej_mask),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data)
   );

   slot_hp_slots #(.NUM_SLOTS(NUM_SLOTS)) u_slots (
      .clk       (clk),
      .rst_n     (rst_n),
      .reset_req (reset_req),
      .ej_mask   (ej_mask),
      .ins_evt   (ins_evt),
      .rem_evt   (rem_evt),
      .cold_ins  (cold_ins),
      .occupied  (occupied),
      .fixed_fn  (fixed_fn),
      .present   (present),
      .removable (removable),
      .pending   (pending),
      .busy      (busy),
      .hp_event  (hp_event)
   );

   slot_hp_gpe #(.HP_BIT(HP_BIT), .SCI_REG(1'b0)) u_gpe (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (hp_event),
      .clr     (gpe_clr),
      .en      (gpe_en),
      .sts     (gpe_sts),
      .sci     (sci)
   );

   // R6
   cold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !reset_req && (|cold_ins) && !(|ins_evt) && !(|rem_evt) && !gpe_sts[HP_BIT])
      |=> !gpe_sts[HP_BIT]);

   // R8
   ins_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !reset_req && (|(ej_mask & ins_evt))) |=> (|(present & $past(ej_mask))));

endmodule

// File: tb/sim_slot_hp_ctrl.sv
`timescale 1ns/1ps
module sim_slot_hp_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reset_req = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [3:0]  req_addr = '0, req_be = '0;
   logic [31:0] req_wdata = '0;
   logic        rd_valid;
   logic [31:0] rd_data;
   logic [31:0] ins_evt = '0, rem_evt = '0, cold_ins = '0, occupied = '0, fixed_fn = '0;
   logic [7:0]  gpe_en = '0, gpe_clr = '0, gpe_sts;
   logic        sci, busy;

   int checks = 0, fails = 0;

   always #5 clk = ~clk;

   slot_hp_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .reset_req(reset_req),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_be(req_be), .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
      .ins_evt(ins_evt), .rem_evt(rem_evt), .cold_ins(cold_ins),
      .occupied(occupied), .fixed_fn(fixed_fn),
      .gpe_en(gpe_en), .gpe_clr(gpe_clr), .gpe_sts(gpe_sts), .sci(sci), .busy(busy)
   );

   // behavioural reference
   logic [31:0] m_pres, m_rmv, m_pend, m_rd;
   logic [7:0]  m_sts;
   bit          m_busy, m_rv;

   function automatic int low_idx(input logic [31:0] v);
      for (int i = 0; i < 32; i++) if (v[i]) return i;
      return -1;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pres = 0; m_rmv = '1; m_pend = 0; m_sts = 0;
         m_busy = 1; m_rv = 0; m_rd = 0;
      end else begin
         bit ok;
         logic [31:0] rd;
         logic [7:0] sn;
         int k;
         ok = req_valid && req_be == 4'hF && req_addr[1:0] == 2'b00;
         rd = 0;
         if (ok && !req_write) begin
            case (req_addr[3:2])
               2'd0: rd = m_pres & m_rmv;
               2'd1: rd = m_pend;
               2'd3: rd = m_rmv;
               default: rd = 0;
            endcase
         end
         sn = m_sts & ~gpe_clr;
         if (m_busy) begin
            if (m_pend != 0) begin
               k = low_idx(m_pend);
               m_pend[k] = 1'b0;
               if (!fixed_fn[k]) m_pres[k] = 1'b0;
            end else begin
               m_pres = occupied;
               m_rmv  = ~(occupied & fixed_fn);
               m_busy = 0;
            end
         end else if (reset_req) begin
            m_busy = 1;
         end else begin
            if (ok && req_write && req_addr[3:2] == 2'd2) begin
               k = low_idx(req_wdata);
               if (k >= 0) begin
                  m_pend[k] = 1'b0;
                  if (!fixed_fn[k]) m_pres[k] = 1'b0;
               end
            end
            m_pend = m_pend | rem_evt;
            m_pres = m_pres | ins_evt | cold_ins;
            if (ins_evt != 0 || rem_evt != 0) sn[1] = 1'b1;
         end
         m_sts = sn;
         m_rv  = req_valid && !req_write;
         m_rd  = rd;
      end
   end

   task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
      end
   endtask

   // compare against the reference every cycle, away from the rising edge
   always @(negedge clk) begin
      if (rst_n) begin
         cmp("R9", "busy", 32'(busy), 32'(m_busy));
         cmp("R5", "gpe_sts", 32'(gpe_sts), 32'(m_sts));
         cmp("R7", "sci", 32'(sci), 32'(|(m_sts & gpe_en)));
         cmp("R1", "rd_valid", 32'(rd_valid), 32'(m_rv));
         if (m_rv) cmp("R2", "rd_data", rd_data, m_rd);
      end
   end

   task automatic step();
      @(negedge clk); #1;
   endtask

   task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
      req_valid = 1; req_write = 0; req_addr = a; req_be = 4'hF;
      step();
      req_valid = 0;
      cmp(req, "read", rd_data, exp);
   endtask

   task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
      req_valid = 1; req_write = 1; req_addr = a; req_be = be; req_wdata = d;
      step();
      req_valid = 0; req_write = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL R9 watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int n;
      occupied = 32'h0000_00F3;
      fixed_fn = 32'h0000_0001;
      repeat (3) step();
      cmp("R10", "busy in reset", 32'(busy), 32'd1);
      cmp("R5", "gpe_sts in reset", 32'(gpe_sts), 32'd0);
      rst_n = 1;
      step();
      cmp("R10", "busy after rebuild", 32'(busy), 32'd0);
      rd_chk(4'hC, 32'hFFFF_FFFE, "R3");
      rd_chk(4'h0, 32'h0000_00F2, "R2");
      rd_chk(4'h8, 32'h0, "R3");

      // hot insert slot 8, interrupt and clear
      gpe_en = 8'h02;
      ins_evt = 32'h100; step(); ins_evt = 0;
      cmp("R5", "hot insert status", 32'(gpe_sts), 32'h02);
      cmp("R7", "sci high", 32'(sci), 32'd1);
      rd_chk(4'h0, 32'h0000_01F2, "R5");
      gpe_clr = 8'h02; step(); gpe_clr = 0;
      cmp("R7", "sci cleared", 32'(sci), 32'd0);

      // coldplug slot 9
      cold_ins = 32'h200; step(); cold_ins = 0;
      cmp("R6", "coldplug status", 32'(gpe_sts), 32'h0);
      cmp("R6", "coldplug sci", 32'(sci), 32'd0);
      rd_chk(4'h0, 32'h0000_03F2, "R6");

      // remove slots 4 and 5, eject clears only the lowest
      rem_evt = 32'h30; step(); rem_evt = 0;
      rd_chk(4'h4, 32'h30, "R5");
      gpe_clr = 8'hFF; step(); gpe_clr = 0;
      wr(4'h8, 4'hF, 32'h30);
      rd_chk(4'h4, 32'h20, "R4");
      rd_chk(4'h0, 32'h0000_03E2, "R4");
      wr(4'h8, 4'h3, 32'h20);
      rd_chk(4'h4, 32'h20, "R1");
      wr(4'h4, 4'hF, 32'h0);
      wr(4'h8, 4'hF, 32'h0);
      rd_chk(4'h4, 32'h20, "R4");

      // fixed-function slot keeps presence on eject
      fixed_fn = 32'h3;
      rem_evt = 32'h2; step(); rem_evt = 0;
      wr(4'h8, 4'hF, 32'h2);
      rd_chk(4'h4, 32'h20, "R4");
      rd_chk(4'h0, 32'h0000_03E2, "R4");

      // same-cycle collisions
      req_valid = 1; req_write = 1; req_addr = 4'h8; req_be = 4'hF; req_wdata = 32'h20;
      ins_evt = 32'h20; step(); ins_evt = 0; req_valid = 0; req_write = 0;
      rd_chk(4'h4, 32'h0, "R8");
      rd_chk(4'h0, 32'h0000_03E2, "R8");
      req_valid = 1; req_write = 1; req_addr = 4'h8; req_be = 4'hF; req_wdata = 32'h40;
      rem_evt = 32'h40; step(); rem_evt = 0; req_valid = 0; req_write = 0;
      rd_chk(4'h4, 32'h40, "R8");

      // reset request drains three pending slots
      rem_evt = 32'h1080; step(); rem_evt = 0;
      occupied = 32'h0000_F00F; fixed_fn = 32'h1;
      reset_req = 1; step(); reset_req = 0;
      n = 0;
      ins_evt = 32'h0010_0000;
      while (busy && n < 20) begin step(); ins_evt = 0; n++; end
      ins_evt = 0;
      cmp("R9", "busy cycles", 32'(n), 32'd4);
      rd_chk(4'h4, 32'h0, "R10");
      rd_chk(4'h0, 32'h0000_F00E, "R10");
      rd_chk(4'hC, 32'hFFFF_FFFE, "R10");

      // random traffic checked against the reference
      for (int c = 0; c < 4000; c++) begin
         ins_evt   = ($urandom % 6 == 0) ? (32'd1 << ($urandom % 32)) : 32'd0;
         rem_evt   = ($urandom % 6 == 0) ? (32'd1 << ($urandom % 32)) : 32'd0;
         cold_ins  = ($urandom % 10 == 0) ? (32'd1 << ($urandom % 32)) : 32'd0;
         gpe_clr   = ($urandom % 4 == 0) ? 8'(($urandom % 256)) : 8'd0;
         gpe_en    = ($urandom % 16 == 0) ? 8'(($urandom % 256)) : gpe_en;
         reset_req = ($urandom % 97 == 0);
         if ($urandom % 40 == 0) occupied = $urandom;
         if ($urandom % 40 == 0) fixed_fn = $urandom & 32'h0F0F_0F0F;
         req_valid = ($urandom % 3 == 0);
         req_write = ($urandom % 2 == 0);
         req_addr  = ($urandom % 8 == 0) ? 4'($urandom % 16) : {2'($urandom % 4), 2'b00};
         req_be    = ($urandom % 10 == 0) ? 4'h7 : 4'hF;
         req_wdata = ($urandom % 2 == 0) ? $urandom : (32'd1 << ($urandom % 32));
         step();
      end
      ins_evt = 0; rem_evt = 0; cold_ins = 0; gpe_clr = 0; reset_req = 0; req_valid = 0;
      repeat (40) step();

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule